// File: doc/BRIEF.md
# Burst-Locked Priority Arbiter with In-Order Command Queue

This block shares one slave port among several masters. Each master raises a request together with a burst length, and the arbiter chooses one winner. The winner is the requester with the numerically lowest priority value. When several requesters share that value, a round-robin pointer kept for each priority level breaks the tie. The grant stays with the winning master until the final beat of its burst has been accepted. A new choice is made only after that, so a long transfer that a master sends as several bursts can be interleaved with bursts from other masters.

Each grant pushes one command into a small bridge queue, made up of the master index and the burst length. The queue drains strictly in order through a ready/valid port. A command that is already in the queue is never overtaken by a later command, whatever the later command's priority. While the queue is full, no grant is issued. Pending requests simply wait.

Top module: `prio_burst_arb`

## Requirements
- R1: After reset, `gnt` is zero, `cmd_valid` is low and every priority value is 0. Every round-robin pointer points at master 0, so when all masters request at one level, master 0 wins first.
- R2: When no burst is active and the queue is not full, the requester with the lowest priority value is granted at the next clock edge. Value 0 is the most urgent.
- R3: Among requesters that share the winning value, the first requesting master at or after that level's pointer wins, counting upward and wrapping. After each grant, that level's pointer moves to the winner's index plus one, modulo the number of masters.
- R4: `req_len` holds the burst length minus one. The grant stays unchanged until that many beats plus one have been accepted (`beat_vld` while `beat_rdy`). `beat_last` is high only on the final beat. `gnt` is zero in the cycle after the final beat is accepted.
- R5: Arbitration happens at every burst boundary. A master that keeps requesting after its burst competes again, and a higher-priority or next-in-turn master requesting at that boundary wins first.
- R6: Every grant enqueues one command, with `cmd_mst` set to the master index and `cmd_len` set to its length field. Commands leave in grant order when `cmd_valid` and `cmd_ready` are both high.
- R7: While the queue holds its full depth of commands, no grant is issued. A request that is held asserted is granted once a command has been drained.
- R8: A priority write (`prio_we`, `prio_sel`, `prio_wdata`) takes effect only while no grant is outstanding. A write made during a burst is ignored.
- R9: `gnt` is one-hot or zero, and a grant goes only to a master that was requesting in the cycle before.
- R10: Single-beat accesses are never merged. Each one gets its own grant and its own queue entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | One request bit per master |
| req_len | input | N_MST*LEN_W | Burst length minus one for each master, one field per master |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | $clog2(N_MST) | Master whose priority is written |
| prio_wdata | input | PRIO_W | New priority value |
| gnt | output | N_MST | One-hot grant |
| beat_vld | input | 1 | Granted master presents a beat |
| beat_rdy | output | 1 | A burst is active and beats are accepted |
| beat_last | output | 1 | The current beat is the last one of the burst |
| cmd_valid | output | 1 | Queue head is valid |
| cmd_ready | input | 1 | Downstream takes the queue head |
| cmd_mst | output | $clog2(N_MST) | Master index of the queue head |
| cmd_len | output | LEN_W | Length field of the queue head |

## Verification
The assertions assume that a master holds `req` and its `req_len` field stable until it is granted. They also assume that the master lowers its request, or replaces it with its next burst, within the burst that the grant opened. Beats are presented only while `beat_rdy` is high. The stimulus keeps to these rules by driving inputs on the falling edge only. It changes a master's request only after checking that the master holds the grant, and it writes priorities only while `gnt` is zero, except in the one case that tests the ignored write.

// File: rtl/prio_burst_arb.sv
module prio_burst_arb #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  parameter int LEN_W  = 4,
  parameter int Q_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MST-1:0]            req,
  input  logic [N_MST*LEN_W-1:0]      req_len,
  input  logic                        prio_we,
  input  logic [$clog2(N_MST)-1:0]    prio_sel,
  input  logic [PRIO_W-1:0]           prio_wdata,
  output logic [N_MST-1:0]            gnt,
  input  logic                        beat_vld,
  output logic                        beat_rdy,
  output logic                        beat_last,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [$clog2(N_MST)-1:0]    cmd_mst,
  output logic [LEN_W-1:0]            cmd_len
);
  localparam int IW   = $clog2(N_MST);
  localparam int NLVL = 1 << PRIO_W;
  localparam int QAW  = $clog2(Q_DEPTH);
  localparam int EW   = IW + LEN_W;

  logic [PRIO_W-1:0] prio   [N_MST];
  logic [IW-1:0]     rr_ptr [NLVL];
  logic [N_MST-1:0]  gnt_q;
  logic [LEN_W-1:0]  beat_cnt;
  logic [EW-1:0]     q_mem  [Q_DEPTH];
  logic [QAW-1:0]    wr_p, rd_p;
  logic [QAW:0]      q_cnt;

  logic [PRIO_W-1:0] best;
  logic              any_req;
  logic [IW-1:0]     win;
  logic              issue, beat_acc, q_full, q_pop;

  always_comb begin
    best = '1;
    any_req = 1'b0;
    for (int i = 0; i < N_MST; i++)
      if (req[i] && (!any_req || prio[i] < best)) begin
        best = prio[i];
        any_req = 1'b1;
      end
    win = '0;
    for (int k = N_MST - 1; k >= 0; k--) begin
      int j;
      j = (int'(rr_ptr[best]) + k) % N_MST;
      if (req[j] && prio[j] == best) win = IW'(j);
    end
  end

  assign q_full    = (q_cnt == (QAW+1)'(Q_DEPTH));
  assign issue     = any_req && (gnt_q == '0) && !q_full;
  assign beat_rdy  = |gnt_q;
  assign beat_last = beat_rdy && (beat_cnt == '0);
  assign beat_acc  = beat_vld && beat_rdy;
  assign gnt       = gnt_q;
  assign q_pop     = cmd_ready && cmd_valid;
  assign cmd_valid = (q_cnt != '0);
  assign {cmd_mst, cmd_len} = q_mem[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      beat_cnt <= '0;
      for (int l = 0; l < NLVL; l++) rr_ptr[l] <= '0;
      for (int m = 0; m < N_MST; m++) prio[m] <= '0;
    end else begin
      if (issue) begin
        gnt_q        <= N_MST'(1) << win;
        beat_cnt     <= req_len[win*LEN_W +: LEN_W];
        rr_ptr[best] <= IW'((int'(win) + 1) % N_MST);
      end else if (beat_acc) begin
        if (beat_cnt == '0) gnt_q <= '0;
        else                beat_cnt <= beat_cnt - 1'b1;
      end
      if (prio_we && gnt_q == '0) prio[prio_sel] <= prio_wdata;
    end
  end

  always_ff @(posedge clk)
    if (issue) q_mem[wr_p] <= {win, req_len[win*LEN_W +: LEN_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      q_cnt <= '0;
    end else begin
      if (issue) wr_p <= (wr_p == QAW'(Q_DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (q_pop) rd_p <= (rd_p == QAW'(Q_DEPTH - 1)) ? '0 : rd_p + 1'b1;
      case ({issue, q_pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_to_requester_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && ($past(gnt) == '0)) |-> (($past(req) & gnt) != '0));

  p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && !(beat_vld && beat_last)) |=> $stable(gnt));

  p_burst_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_last) |=> (gnt == '0));

  p_no_grant_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && gnt == '0) |=> (gnt == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (QAW+1)'(Q_DEPTH));

  p_pop_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !issue) |=> !cmd_valid);
endmodule

// File: tb/prio_burst_arb_test.sv
`timescale 1ns/1ps
module prio_burst_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [15:0] req_len = '0;
  logic        prio_we = 1'b0;
  logic [1:0]  prio_sel = '0;
  logic [2:0]  prio_wdata = '0;
  logic [3:0]  gnt;
  logic        beat_vld = 1'b0;
  logic        beat_rdy, beat_last, cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [1:0]  cmd_mst;
  logic [3:0]  cmd_len;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  prio_burst_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_len(req_len),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .gnt(gnt), .beat_vld(beat_vld), .beat_rdy(beat_rdy), .beat_last(beat_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mst(cmd_mst), .cmd_len(cmd_len)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected command", cmd_mst * 16 + cmd_len, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk((cmd_mst * 16 + cmd_len) == e, "R6 queue order", cmd_mst * 16 + cmd_len, e);
      end
    end
  end

  task automatic set_len(input int m, input int len);
    req_len[m*4 +: 4] = 4'(len);
  endtask

  task automatic set_prio(input int m, input int p);
    prio_we = 1'b1;
    prio_sel = 2'(m);
    prio_wdata = 3'(p);
    @(negedge clk);
    prio_we = 1'b0;
  endtask

  task automatic take(input int m, input int len, input bit hold,
                      input logic [3:0] raise, input string tag);
    exp_q.push_back(m * 16 + len);
    @(negedge clk);
    chk(gnt == 4'(1 << m), tag, gnt, 1 << m);
    if (!hold) req[m] = 1'b0;
    req = req | raise;
    beat_vld = 1'b1;
    for (int b = 0; b <= len; b++) begin
      chk(gnt == 4'(1 << m) && beat_last == (b == len), "R4 burst hold", {gnt, beat_last}, (1 << (m + 1)) | int'(b == len));
      @(negedge clk);
    end
    beat_vld = 1'b0;
    chk(gnt == 4'b0, "R4 release", gnt, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt == 4'b0 && !cmd_valid && !beat_rdy, "R1 reset state", {gnt, cmd_valid, beat_rdy}, 0);

    // R1, R3, R10: all masters at level 0 with single beats
    for (int m = 0; m < 4; m++) set_len(m, 0);
    req = 4'b1111;
    take(0, 0, 0, 4'b0, "R1 pointer starts at master 0");
    take(1, 0, 0, 4'b0, "R10 separate single beat grant");
    take(2, 0, 0, 4'b0, "R10 separate single beat grant");
    take(3, 0, 0, 4'b0, "R10 separate single beat grant");

    // R2 and R8 idle write: distinct priorities
    set_prio(0, 3); set_prio(1, 2); set_prio(2, 1); set_prio(3, 5);
    set_len(0, 1); set_len(1, 2); set_len(2, 0); set_len(3, 3);
    req = 4'b1111;
    take(2, 0, 0, 4'b0, "R2 lowest value wins");
    take(1, 2, 0, 4'b0, "R2 lowest value wins");
    take(0, 1, 0, 4'b0, "R2 lowest value wins");
    take(3, 3, 0, 4'b0, "R2 lowest value wins");

    // R3: ties at level 4
    for (int m = 0; m < 4; m++) begin set_prio(m, 4); set_len(m, 0); end
    req = 4'b1010;
    take(1, 0, 0, 4'b0, "R3 round robin");
    take(3, 0, 0, 4'b0, "R3 round robin skips idle master");
    req = 4'b1011;
    take(0, 0, 0, 4'b0, "R3 pointer wraps");
    take(1, 0, 0, 4'b0, "R3 round robin");
    take(3, 0, 0, 4'b0, "R3 round robin");

    // R5: boundary re-arbitration
    set_prio(2, 0);
    set_len(0, 3); set_len(1, 1); set_len(2, 0);
    req = 4'b0011;
    take(0, 3, 1, 4'b0100, "R5 first burst");
    take(2, 0, 0, 4'b0, "R5 higher priority at boundary");
    take(1, 1, 0, 4'b0, "R5 equal priority interleaves");
    take(0, 3, 0, 4'b0, "R5 continued transfer");

    // R8: write during a burst is ignored
    set_len(2, 2);
    req = 4'b0100;
    exp_q.push_back(2 * 16 + 2);
    @(negedge clk);
    chk(gnt == 4'b0100, "R8 burst open", gnt, 4);
    req = 4'b0;
    beat_vld = 1'b1;
    prio_we = 1'b1; prio_sel = 2'd3; prio_wdata = 3'd7;
    @(negedge clk);
    prio_we = 1'b0;
    repeat (2) @(negedge clk);
    beat_vld = 1'b0;
    set_len(0, 0); set_len(3, 0);
    req = 4'b1001;
    take(3, 0, 0, 4'b0, "R8 write during burst ignored");
    take(0, 0, 0, 4'b0, "R8 write during burst ignored");

    // R7 and R6: fill the queue, then drain
    cmd_ready = 1'b0;
    set_len(1, 0);
    req = 4'b0010; take(1, 0, 0, 4'b0, "R6 fill");
    req = 4'b1000; take(3, 0, 0, 4'b0, "R6 fill");
    req = 4'b0001; take(0, 0, 0, 4'b0, "R6 fill");
    req = 4'b0010; take(1, 0, 0, 4'b0, "R6 fill");
    set_len(2, 0);
    req = 4'b0100;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(gnt == 4'b0, "R7 no grant while full", gnt, 0);
    end
    exp_q.push_back(2 * 16 + 0);
    cmd_ready = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 10 && !seen; c++) begin
        @(negedge clk);
        if (gnt == 4'b0100) seen = 1'b1;
      end
      chk(seen, "R7 held request granted after drain", gnt, 4);
    end
    req = 4'b0;
    beat_vld = 1'b1;
    @(negedge clk);
    beat_vld = 1'b0;
    repeat (8) @(negedge clk);
    chk(!cmd_valid && exp_q.size() == 0, "R6 queue drained in order", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule